// File: doc/BRIEF.md
# Memory Training Data Pattern Generator

This block streams 32-bit data words for memory interface training and stress runs. A controller sets a pattern type, a lane or bit selector, a bus-width flag (full 32-bit bus or 16-bit bus) and a word count, then pulses `start`. The block captures that setup, walks an internal index upward from zero, and offers one word per cycle on a valid/ready handshake. Once the last word has been accepted, it raises `done` for one cycle.

Each word is computed from the current index and the captured setup. The index feeds a handful of small arithmetic rules and three 64-bit constant bitmaps. These give the stress patterns: aggressor/victim crosstalk per data lane, simultaneous switching, full-crosstalk and crosstalk-free single-bit stimulus, inter-symbol interference, a reference-voltage sweep, per-bit skew words, read-leveling markers and a short test pattern. Several of the rules change when the 16-bit bus flag is set. A type code with no rule gives all-zero words and sets a sticky error flag, which the next start clears.

Top module: `train_pattern_gen`

## Requirements
- R1: `start` captures the setup and sets the index to 0. `out_valid` is high while index < count, and `out_data` is the word for the current index. The index advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the index and `out_data` hold. Exactly `count` words are accepted per run. The reset state has `out_valid`, `done` and `type_err` low.
- R2: `done` is high for exactly one cycle, the cycle after the final word is accepted, and `out_valid` is low in that cycle. A start with count 0 emits no word and gives `done` in the cycle after `start`.
- R3: Type, lane, bus flag and count are captured only when `start` is high. Changes to them during a run have no effect on the words or on their number.
- R4: Type 6 (aggressor/victim), full width. Index i uses row r = i mod 64 of the row table. Byte bit j takes the row's aggressor bit when j equals `cfg_lane`, and the row's victim bit otherwise. The byte is repeated in all four byte lanes.
- R5: Type 6, 16-bit mode. Index i uses k = i mod 32. The byte built from row 2k fills bytes 1:0, and the byte built from row 2k+1 fills bytes 3:2.
- R6: Type 8 (simultaneous switching) with s = `cfg_lane[1:0]`. Full width gives all ones when floor(i/(s+1)) is odd, and zeros otherwise. In 16-bit mode, s = 0 gives 0x0000FFFF, and s > 0 uses divisor s instead of s+1.
- R7: Type 10 (full crosstalk). Let b = 1 << `cfg_lane`. On odd indices b is inverted. Full width repeats b in all four bytes. In 16-bit mode, bytes 1:0 carry b and bytes 3:2 carry ~b.
- R8: Type 11 (crosstalk-free), with b = 1 << `cfg_lane`. Full width gives b in all four bytes on even indices and zero on odd indices. In 16-bit mode, even indices put b in bytes 3:2 only, and odd indices put it in bytes 1:0 only.
- R9: Type 12 (inter-symbol interference). Full width: a = i mod 32 and b = i mod 8. For a > 15 the word is all ones when b is 5 or 7. For a ≤ 15 it is all ones when b is 6. The word is inverted when (a mod 16) > 7. 16-bit mode: a = i mod 16 and b = i mod 4. For a > 7 the word is 0x0000FFFF when b > 1. For a ≤ 7 it is 0xFFFF0000 when b = 3. Otherwise the word is 0, and it is inverted when (a mod 8) > 3.
- R10: Type 9 (reference voltage). Full width gives all ones when bit (i mod 8) of map byte (i/8 mod 8) is set. The map bytes from position 0 up are B8, 52, 55, 8A, 33, A6, 6D, FE. 16-bit mode, with k = i mod 32: the victim bit of row 2k sets bytes 3:2 to FF, and the victim bit of row 2k+1 sets bytes 1:0 to FF.
- R11: Skew types. Types 0 and 1, full width, give 0x55555555 at indices 0, 2, 5 and 7, and 0xAAAAAAAA elsewhere. Type 2, full width, gives 0x55555555 on even indices and 0xAAAAAAAA on odd indices. Types 0–2 in 16-bit mode give 0x55AA55AA. Type 5, full width, repeats the byte (((0xFF << floor(i/3)) & 0xFF00) >> 8) in all four bytes; in 16-bit mode it gives 0x00FF00FF.
- R12: Type 3 gives zeros for i < 6 (full width) or i < 3 (16-bit), and 0x80808080 after that. Type 4 behaves the same with 0x01010101. Type 7 gives zeros for i in 2..5 (full width) or for i in {0, 3} (16-bit), and 0xFFFFFFFF otherwise.
- R13: Types 13–15 give all-zero words and set `type_err`. `type_err` holds until the next `start`, which clears it, or sets it again if the new type is also 13–15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run with the presented setup |
| cfg_type | input | 4 | Pattern type code |
| cfg_lane | input | 3 | Target lane/bit, or switching parameter in bits 1:0 |
| cfg_half | input | 1 | 1 selects 16-bit bus rules |
| cfg_count | input | CNT_W | Number of words in the run |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | A word is offered |
| out_data | output | 32 | Pattern word |
| done | output | 1 | One-cycle pulse after the final word |
| type_err | output | 1 | Sticky flag for an unsupported type |

## Verification
A wrong index or a lost stall shows at the ports at once: the first word after the error differs from the value the bench computes from its index. A corrupted captured count or setup shows as an extra or missing word, or as `done` arriving in the wrong cycle. Both are visible within one run. A wrong row bit in a constant bitmap shows only at the index that reads that row, so every type is swept over 64 indices in both bus modes. The random runs add stalls and changing setup inputs on top of that sweep.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  typedef enum logic [3:0] {
    PT_SKEW_A   = 4'd0,
    PT_SKEW_B   = 4'd1,
    PT_SKEW_ALT = 4'd2,
    PT_RDLVL_HI = 4'd3,
    PT_RDLVL_LO = 4'd4,
    PT_SKEW_STA = 4'd5,
    PT_AGG_VIC  = 4'd6,
    PT_TEST     = 4'd7,
    PT_SWITCH   = 4'd8,
    PT_VREF     = 4'd9,
    PT_XT_FULL  = 4'd10,
    PT_XT_FREE  = 4'd11,
    PT_ISI      = 4'd12
  } ptg_type_e;

  localparam logic [3:0] PT_LAST = 4'd12;

  // Row tables: bit r belongs to row r.
  localparam logic [63:0] AGG_ROWS = 64'hFFE0_A6B2_0AD5_2D4D;
  localparam logic [63:0] VIC_ROWS = 64'hFE6D_A6B3_8A55_52B8;
  // Reference-voltage map: byte n holds map entry n.
  localparam logic [63:0] VREF_MAP = 64'hFE6D_A633_8A55_52B8;

  function automatic logic type_ok(input logic [3:0] t);
    return t <= PT_LAST;
  endfunction

endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cfg_type,
  input  logic [2:0]       cfg_lane,
  input  logic             cfg_half,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             done,
  output logic             type_err,
  output logic [CNT_W-1:0] idx_q,
  output logic [3:0]       type_q,
  output logic [2:0]       lane_q,
  output logic             half_q
);
  import ptg_pkg::*;

  logic             rst_m, rst_s;
  logic             act_q, act_n;
  logic [CNT_W-1:0] idx_n, cnt_q;
  logic             done_n, err_n;
  logic             beat, last_beat;

  // Reset: asserts immediately, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign beat      = act_q && out_ready;
  assign last_beat = beat && (idx_q == cnt_q - CNT_W'(1));

  always_comb begin
    act_n  = act_q;
    idx_n  = idx_q;
    done_n = 1'b0;
    err_n  = type_err;
    if (start) begin
      act_n  = (cfg_count != '0);
      idx_n  = '0;
      done_n = (cfg_count == '0);
      err_n  = !type_ok(cfg_type);
    end else if (beat) begin
      if (last_beat) begin
        act_n  = 1'b0;
        done_n = 1'b1;
      end else begin
        idx_n = idx_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      act_q    <= 1'b0;
      idx_q    <= '0;
      done     <= 1'b0;
      type_err <= 1'b0;
    end else begin
      act_q    <= act_n;
      idx_q    <= idx_n;
      done     <= done_n;
      type_err <= err_n;
    end
  end

  // Setup capture, enabled by start only.
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q  <= '0;
      type_q <= '0;
      lane_q <= '0;
      half_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= cfg_count;
      type_q <= cfg_type;
      lane_q <= cfg_lane;
      half_q <= cfg_half;
    end
  end

  assign out_valid = act_q;

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && !out_ready && !start |=> out_valid && $stable(idx_q));
  p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> idx_q < cnt_q);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> !out_valid);
  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> $past(last_beat || (start && cfg_count == '0)));
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_s)
    !start |=> $stable(cnt_q) && $stable(type_q) && $stable(lane_q) && $stable(half_q));
  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_s)
    !start |=> $stable(type_err));

endmodule

// File: rtl/ptg_word.sv
module ptg_word #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] idx,
  input  logic [3:0]       ptype,
  input  logic [2:0]       lane,
  input  logic             half,
  output logic [31:0]      word
);
  import ptg_pkg::*;

  logic [CNT_W-1:0] q2, q3, q4;
  logic [5:0]       row_f, row_e, row_o;
  logic [7:0]       byte_f, byte_e, byte_o, hot, xt;
  logic [15:0]      sta_sh;
  logic [7:0]       sta_b;
  logic             sw_bit, isi_bit, isi_inv;
  logic [31:0]      isi16;

  function automatic logic [7:0] row_byte(input logic [5:0] r, input logic [2:0] ln);
    logic [7:0] b;
    for (int j = 0; j < 8; j++)
      b[j] = (j == int'(ln)) ? AGG_ROWS[r] : VIC_ROWS[r];
    return b;
  endfunction

  assign q2 = idx >> 1;
  assign q3 = idx / CNT_W'(3);
  assign q4 = idx >> 2;

  assign row_f  = idx[5:0];
  assign row_e  = {idx[4:0], 1'b0};
  assign row_o  = {idx[4:0], 1'b1};
  assign byte_f = row_byte(row_f, lane);
  assign byte_e = row_byte(row_e, lane);
  assign byte_o = row_byte(row_o, lane);

  assign hot    = 8'd1 << lane;
  assign xt     = idx[0] ? ~hot : hot;
  assign sta_sh = 16'h00FF << q3[3:0];
  assign sta_b  = (q3 >= CNT_W'(16)) ? 8'h00 : sta_sh[15:8];

  always_comb begin
    if (!half) begin
      unique case (lane[1:0])
        2'd0:    sw_bit = idx[0];
        2'd1:    sw_bit = q2[0];
        2'd2:    sw_bit = q3[0];
        default: sw_bit = q4[0];
      endcase
    end else begin
      unique case (lane[1:0])
        2'd1:    sw_bit = idx[0];
        2'd2:    sw_bit = q2[0];
        default: sw_bit = q3[0];
      endcase
    end
  end

  // Interference: full width period 32, half width period 16.
  always_comb begin
    isi_bit = idx[4] ? (idx[2:0] == 3'd5 || idx[2:0] == 3'd7) : (idx[2:0] == 3'd6);
    isi_inv = idx[3];
    if (idx[3])
      isi16 = idx[1] ? 32'h0000_FFFF : 32'h0;
    else
      isi16 = (idx[1:0] == 2'd3) ? 32'hFFFF_0000 : 32'h0;
    if (idx[2]) isi16 = ~isi16;
  end

  always_comb begin
    word = 32'h0;
    unique case (ptype)
      PT_SKEW_A, PT_SKEW_B:
        word = half ? 32'h55AA_55AA :
               (idx == CNT_W'(0) || idx == CNT_W'(2) || idx == CNT_W'(5) || idx == CNT_W'(7))
               ? 32'h5555_5555 : 32'hAAAA_AAAA;
      PT_SKEW_ALT:
        word = half ? 32'h55AA_55AA : (idx[0] ? 32'hAAAA_AAAA : 32'h5555_5555);
      PT_RDLVL_HI, PT_RDLVL_LO: begin
        if (idx < (half ? CNT_W'(3) : CNT_W'(6))) word = 32'h0;
        else word = (ptype == PT_RDLVL_HI) ? 32'h8080_8080 : 32'h0101_0101;
      end
      PT_SKEW_STA:
        word = half ? 32'h00FF_00FF : {4{sta_b}};
      PT_AGG_VIC:
        word = half ? {byte_o, byte_o, byte_e, byte_e} : {4{byte_f}};
      PT_TEST: begin
        if (half) word = (idx == CNT_W'(0) || idx == CNT_W'(3)) ? 32'h0 : 32'hFFFF_FFFF;
        else      word = (idx >= CNT_W'(2) && idx <= CNT_W'(5)) ? 32'h0 : 32'hFFFF_FFFF;
      end
      PT_SWITCH:
        word = (half && lane[1:0] == 2'd0) ? 32'h0000_FFFF : {32{sw_bit}};
      PT_VREF:
        word = half ? {{16{VIC_ROWS[row_e]}}, {16{VIC_ROWS[row_o]}}}
                    : {32{VREF_MAP[{idx[5:3], idx[2:0]}]}};
      PT_XT_FULL:
        word = half ? {~xt, ~xt, xt, xt} : {4{xt}};
      PT_XT_FREE: begin
        if (half) word = idx[0] ? {16'h0, hot, hot} : {hot, hot, 16'h0};
        else      word = idx[0] ? 32'h0 : {4{hot}};
      end
      PT_ISI:
        word = half ? isi16 : {32{isi_bit ^ isi_inv}};
      default: word = 32'h0;
    endcase
  end

endmodule

// File: rtl/train_pattern_gen.sv
module train_pattern_gen #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       cfg_type,
  input  logic [2:0]       cfg_lane,
  input  logic             cfg_half,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             done,
  output logic             type_err
);

  logic [CNT_W-1:0] idx_q;
  logic [3:0]       type_q;
  logic [2:0]       lane_q;
  logic             half_q;

  ptg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_type  (cfg_type),
    .cfg_lane  (cfg_lane),
    .cfg_half  (cfg_half),
    .cfg_count (cfg_count),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .done      (done),
    .type_err  (type_err),
    .idx_q     (idx_q),
    .type_q    (type_q),
    .lane_q    (lane_q),
    .half_q    (half_q)
  );

  ptg_word #(.CNT_W(CNT_W)) u_word (
    .idx   (idx_q),
    .ptype (type_q),
    .lane  (lane_q),
    .half  (half_q),
    .word  (out_data)
  );

  p_stall_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> $stable(out_data));
  p_err_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    type_err && out_valid |-> out_data == 32'h0);

endmodule

// File: tb/train_pattern_gen_bench.sv
module train_pattern_gen_bench;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [3:0]       cfg_type;
  logic [2:0]       cfg_lane;
  logic             cfg_half;
  logic [CNT_W-1:0] cfg_count;
  logic             out_ready;
  logic             out_valid;
  logic [31:0]      out_data;
  logic             done;
  logic             type_err;

  int checks = 0;
  int fails  = 0;

  localparam logic [63:0] AGG = 64'hFFE0_A6B2_0AD5_2D4D;
  localparam logic [63:0] VIC = 64'hFE6D_A6B3_8A55_52B8;
  localparam logic [7:0]  VMAP [8] = '{8'hB8, 8'h52, 8'h55, 8'h8A, 8'h33, 8'hA6, 8'h6D, 8'hFE};

  always #4 clk = ~clk;

  train_pattern_gen #(.CNT_W(CNT_W)) u_train_pattern_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_type(cfg_type),
    .cfg_lane(cfg_lane), .cfg_half(cfg_half), .cfg_count(cfg_count),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .done(done), .type_err(type_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] av_byte(input int row, input int ln);
    logic [7:0] b = 8'h0;
    for (int j = 0; j < 8; j++) b[j] = (j == ln) ? AGG[row % 64] : VIC[row % 64];
    return b;
  endfunction

  function automatic logic [31:0] model(input int t, input int ln, input bit h, input int i);
    logic [7:0]  b;
    logic [31:0] w;
    int a, c, s;
    case (t)
      0, 1: return h ? 32'h55AA55AA : ((i == 0 || i == 2 || i == 5 || i == 7) ? 32'h55555555 : 32'hAAAAAAAA);
      2: return h ? 32'h55AA55AA : ((i % 2 == 0) ? 32'h55555555 : 32'hAAAAAAAA);
      3: return (i < (h ? 3 : 6)) ? 32'h0 : 32'h80808080;
      4: return (i < (h ? 3 : 6)) ? 32'h0 : 32'h01010101;
      5: begin
        if (h) return 32'h00FF00FF;
        w = ((32'hFF << (i / 3)) & 32'hFF00) >> 8;
        return {4{w[7:0]}};
      end
      6: begin
        if (!h) return {4{av_byte(i, ln)}};
        a = i % 32;
        return {av_byte(2*a+1, ln), av_byte(2*a+1, ln), av_byte(2*a, ln), av_byte(2*a, ln)};
      end
      7: if (h) return (i == 0 || i == 3) ? 32'h0 : 32'hFFFFFFFF;
         else return (i >= 2 && i <= 5) ? 32'h0 : 32'hFFFFFFFF;
      8: begin
        s = ln % 4;
        if (h && s == 0) return 32'h0000FFFF;
        c = h ? s : s + 1;
        return ((i / c) % 2 == 1) ? 32'hFFFFFFFF : 32'h0;
      end
      9: begin
        if (!h) return VMAP[(i / 8) % 8][i % 8] ? 32'hFFFFFFFF : 32'h0;
        a = i % 32;
        return {{16{VIC[2*a]}}, {16{VIC[2*a+1]}}};
      end
      10: begin
        b = 8'd1 << ln;
        if (i % 2 == 1) b = ~b;
        return h ? {~b, ~b, b, b} : {4{b}};
      end
      11: begin
        b = 8'd1 << ln;
        if (h) return (i % 2 == 0) ? {b, b, 16'h0} : {16'h0, b, b};
        return (i % 2 == 0) ? {4{b}} : 32'h0;
      end
      12: begin
        if (!h) begin
          a = i % 32; c = i % 8;
          w = (a > 15) ? ((c == 5 || c == 7) ? '1 : '0) : ((c == 6) ? '1 : '0);
          return ((a % 16) > 7) ? ~w : w;
        end
        a = i % 16; c = i % 4;
        w = (a > 7) ? ((c > 1) ? 32'h0000FFFF : 32'h0) : ((c == 3) ? 32'hFFFF0000 : 32'h0);
        return ((a % 8) > 3) ? ~w : w;
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int t, input bit h);
    case (t)
      0, 1, 2, 5: return "R11";
      3, 4, 7:    return "R12";
      6:          return h ? "R5" : "R4";
      8:          return "R6";
      9:          return "R10";
      10:         return "R7";
      11:         return "R8";
      12:         return "R9";
      default:    return "R13";
    endcase
  endfunction

  // One run: start, then handshake until the expected done cycle.
  task automatic run(input int t, input int ln, input bit h, input int cnt, input bit scramble);
    int  idx = 0;
    int  guard = 0;
    bit  rdy;
    @(negedge clk);
    start = 1'b1; cfg_type = 4'(t); cfg_lane = 3'(ln); cfg_half = h; cfg_count = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    chk(type_err == (t > 12), "R13 err after start", 32'(type_err), 32'(t > 12));
    while (guard < 4 * cnt + 10) begin
      guard++;
      if (scramble) begin
        cfg_type = 4'($urandom); cfg_lane = 3'($urandom);
        cfg_half = 1'($urandom); cfg_count = CNT_W'($urandom);
      end
      if (idx == cnt) begin
        chk(done == 1'b1, "R2 done pulse", 32'(done), 32'd1);
        chk(out_valid == 1'b0, "R2 valid low at done", 32'(out_valid), 32'd0);
        break;
      end
      chk(done == 1'b0, "R2 no early done", 32'(done), 32'd0);
      chk(out_valid == 1'b1, "R1 valid in run", 32'(out_valid), 32'd1);
      chk(out_data == model(t, ln, h, idx), scramble ? "R3 word under setup change" : tag_of(t, h),
          out_data, model(t, ln, h, idx));
      rdy = ($urandom % 4) != 0;
      out_ready = rdy;
      if (rdy) idx++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R2 single-cycle done", 32'(done), 32'd0);
    chk(type_err == (t > 12), "R13 sticky err", 32'(type_err), 32'(t > 12));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst_n = 1'b0; start = 1'b0; cfg_type = '0; cfg_lane = '0; cfg_half = 1'b0;
    cfg_count = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
    chk(done == 1'b0, "R2 reset done", 32'(done), 32'd0);
    chk(type_err == 1'b0, "R13 reset err", 32'(type_err), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Full sweep of every type in both bus modes.
    for (int t = 0; t < 16; t++)
      for (int h = 0; h < 2; h++)
        run(t, int'($urandom % 8), 1'(h), 64, 1'b0);

    // Count zero and a single word.
    run(7, 0, 1'b0, 0, 1'b0);
    run(12, 0, 1'b0, 1, 1'b0);
    // Setup changes mid-run are ignored.
    run(6, 3, 1'b0, 40, 1'b1);
    run(8, 2, 1'b1, 40, 1'b1);
    // Error set, then cleared by a good start.
    run(14, 0, 1'b0, 5, 1'b0);
    run(10, 5, 1'b1, 8, 1'b0);

    // Random runs.
    for (int n = 0; n < 60; n++)
      run(int'($urandom % 16), int'($urandom % 8), 1'($urandom), int'($urandom % 50), 1'($urandom));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule